// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block is a memory-mapped interrupt controller shared by up to four processors. Each cycle it samples the level-sensitive device request lines into a system pending register. A single system-wide mask decides which of those requests may interrupt. A target register picks the one CPU that receives them. Each CPU also owns a block of software interrupt bits. Any CPU may raise or drop these bits in its own block or in another CPU's block, so they also serve as inter-processor interrupts. A per-CPU timer line raises a fixed level-14 request for that CPU alone.

For every CPU the block drives a 4-bit priority level. This is the highest level among the enabled requests routed to that CPU, and 0 means none. Software works through a simple register bus with one write per cycle and a combinational read. Each CPU's register block sits on its own page, and the system registers follow on the page after the last CPU.

Top module: `irq_route`

## Requirements
- R1: Writes to any of the set or clear registers act only on the one bits of the written word. Zero bits leave the matching state bits unchanged.
- R2: Writing ones to the system clear register (system page offset 0x8) clears those mask bits, which enables the sources. Writing ones to the system set register (offset 0xC) sets them, which disables the sources. The mask reads back at offset 0x4 and resets to all ones.
- R3: While mask bit 31 is set, no system source contributes to any CPU's level, whatever the other mask bits are.
- R4: CPU n's block is page n (page = 4096 bytes). Its pending register is readable at offset 0x0, its clear register at 0x4 and its set register at 0x8. The system block is page NCPU. A write to one CPU's block does not change another CPU's state.
- R5: Software bit 16+L (L = 1..15) of a CPU block requests level L on that CPU, even when the write comes from another CPU (inter-processor interrupt). The bit stays pending until a one is written to it in that CPU's clear register.
- R6: The target register at system offset 0x10 is readable and writable and resets to CPU 0. Only the target CPU receives system sources.
- R7: Unmasked system sources give fixed levels: bit 18 gives 4, bit 16 gives 6, bit 20 gives 8, bit 30 gives 9, bit 19 gives 10, bit 22 gives 11, bits 14 and 15 give 12, and bit 17 gives 13.
- R8: Expansion slot bits 7 to 13 give levels 2, 3, 5, 7, 9, 11 and 13 in that order.
- R9: A high per-CPU timer input appears as bit 7 of that CPU's pending register one cycle later, and it requests level 14 on that CPU only.
- R10: Each CPU's output level is the highest level among its routed, enabled requests. It is 0 when there are none.
- R11: The system pending register (system offset 0x0) returns the device inputs sampled on the previous clock edge, limited to the defined source bits (mask 0x405FFF80), regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 32 | Level device request lines, sampled each cycle |
| cpu_timer | input | NCPU | Per-CPU level-14 timer request lines |
| bus_addr | input | PAGE_W+IDX_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_pil | output | 4*NCPU | Priority level for each CPU, CPU n in bits 4n+3:4n |

## Verification
The embedded assertions check several rules on every cycle. A set write leaves its one bits masked, a clear write leaves them enabled, and an all-zero write leaves the mask unchanged. Software bits never drop without a clear write to their own block. A CPU that is not the target, or any CPU while mask-all is on, stays at level 0 unless it has local requests. A pending timer always lifts its CPU to at least 14. The fixed level table, the choice of the highest among competing requests, raw readback of the sampled sources, and inter-processor signalling between specific blocks are shown only by the bench's directed scenarios.

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NCPU   = 4,
  parameter int PAGE_W = 12,
  localparam int IDX_W  = $clog2(NCPU + 1),
  localparam int ADDR_W = PAGE_W + IDX_W,
  localparam int TGT_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         dev_irq,
  input  logic [NCPU-1:0]     cpu_timer,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [4*NCPU-1:0]   cpu_pil
);

  localparam logic [31:0] SRC_BITS  = 32'h405F_FF80;
  localparam logic [31:0] SOFT_BITS = 32'hFFFE_0000;

  localparam logic [PAGE_W-1:0] OFF_C_PEND = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] OFF_C_CLR  = PAGE_W'(4);
  localparam logic [PAGE_W-1:0] OFF_C_SET  = PAGE_W'(8);
  localparam logic [PAGE_W-1:0] OFF_S_PEND = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] OFF_S_MASK = PAGE_W'(4);
  localparam logic [PAGE_W-1:0] OFF_S_CLR  = PAGE_W'(8);
  localparam logic [PAGE_W-1:0] OFF_S_SET  = PAGE_W'(12);
  localparam logic [PAGE_W-1:0] OFF_S_TGT  = PAGE_W'(16);

  logic [31:0]      sys_pend_q;
  logic [31:0]      mask_q;
  logic [TGT_W-1:0] tgt_q;
  logic [31:0]      soft_q [NCPU];
  logic [NCPU-1:0]  tick_q;

  logic [IDX_W-1:0]  page;
  logic [PAGE_W-1:0] off;
  logic              sys_sel;
  logic [31:0]       sys_live;

  assign page     = bus_addr[ADDR_W-1:PAGE_W];
  assign off      = bus_addr[PAGE_W-1:0];
  assign sys_sel  = (page == IDX_W'(NCPU));
  assign sys_live = sys_pend_q & ~mask_q;

  function automatic logic [3:0] bit_level(input int i);
    case (i)
      7:       return 4'd2;
      8:       return 4'd3;
      9:       return 4'd5;
      10:      return 4'd7;
      11:      return 4'd9;
      12:      return 4'd11;
      13:      return 4'd13;
      14, 15:  return 4'd12;
      16:      return 4'd6;
      17:      return 4'd13;
      18:      return 4'd4;
      19:      return 4'd10;
      20:      return 4'd8;
      22:      return 4'd11;
      30:      return 4'd9;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] sys_max(input logic [31:0] v);
    logic [3:0] best;
    best = 4'd0;
    for (int i = 0; i < 32; i++)
      if (v[i] && bit_level(i) > best) best = bit_level(i);
    return best;
  endfunction

  function automatic logic [3:0] soft_max(input logic [31:0] v);
    logic [3:0] best;
    best = 4'd0;
    for (int l = 1; l < 16; l++)
      if (v[16+l]) best = 4'(l);
    return best;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_pend_q <= '0;
      mask_q     <= '1;
      tgt_q      <= '0;
      tick_q     <= '0;
      for (int c = 0; c < NCPU; c++) soft_q[c] <= '0;
    end else begin
      sys_pend_q <= dev_irq & SRC_BITS;
      tick_q     <= cpu_timer;
      if (bus_we && sys_sel) begin
        case (off)
          OFF_S_CLR: mask_q <= mask_q & ~bus_wdata;
          OFF_S_SET: mask_q <= mask_q | bus_wdata;
          OFF_S_TGT: tgt_q  <= bus_wdata[TGT_W-1:0];
          default: ;
        endcase
      end
      for (int c = 0; c < NCPU; c++) begin
        if (bus_we && page == IDX_W'(c)) begin
          if (off == OFF_C_CLR) soft_q[c] <= soft_q[c] & ~(bus_wdata & SOFT_BITS);
          if (off == OFF_C_SET) soft_q[c] <= soft_q[c] | (bus_wdata & SOFT_BITS);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sys_sel) begin
      case (off)
        OFF_S_PEND: bus_rdata = sys_pend_q;
        OFF_S_MASK: bus_rdata = mask_q;
        OFF_S_TGT:  bus_rdata = 32'(tgt_q);
        default: ;
      endcase
    end else begin
      for (int c = 0; c < NCPU; c++)
        if (page == IDX_W'(c) && off == OFF_C_PEND)
          bus_rdata = soft_q[c] | {24'd0, tick_q[c], 7'd0};
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [3:0] lvl_soft, lvl_local, lvl_sys;
    assign lvl_soft  = soft_max(soft_q[c]);
    assign lvl_local = (tick_q[c] && lvl_soft < 4'd14) ? 4'd14 : lvl_soft;
    assign lvl_sys   = (tgt_q == TGT_W'(c) && !mask_q[31]) ? sys_max(sys_live) : 4'd0;
    assign cpu_pil[4*c +: 4] = (lvl_sys > lvl_local) ? lvl_sys : lvl_local;

    AST_MASKALL_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[31] && soft_q[c] == '0 && !tick_q[c]) |-> cpu_pil[4*c +: 4] == 4'd0); // R3
    AST_UNTARGETED_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q != TGT_W'(c) && soft_q[c] == '0 && !tick_q[c]) |-> cpu_pil[4*c +: 4] == 4'd0); // R6
    AST_SOFT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && page == IDX_W'(c) && off == OFF_C_CLR)
      |=> ((soft_q[c] & $past(soft_q[c])) == $past(soft_q[c]))); // R5
    AST_TICK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q[c] |-> cpu_pil[4*c +: 4] >= 4'd14); // R9
  end

  logic wr_s_set, wr_s_clr, wr_s_tgt;
  assign wr_s_set = bus_we && sys_sel && off == OFF_S_SET;
  assign wr_s_clr = bus_we && sys_sel && off == OFF_S_CLR;
  assign wr_s_tgt = bus_we && sys_sel && off == OFF_S_TGT;

  AST_SET_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s_set |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_CLEAR_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s_clr |=> ((mask_q & $past(bus_wdata)) == 32'd0)); // R2
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_s_set || wr_s_clr) && bus_wdata == 32'd0) |=> $stable(mask_q)); // R1
  AST_TGT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s_tgt |=> tgt_q == $past(bus_wdata[TGT_W-1:0])); // R6

endmodule

// File: tb/tb_irq_route.sv
module tb_irq_route;
  localparam int NCPU = 4;
  localparam int PAGE_W = 12;
  localparam int AW = PAGE_W + 3;
  localparam logic [AW-1:0] SYS = AW'(NCPU << PAGE_W);

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [31:0] dev_irq = '0, bus_wdata = '0, bus_rdata;
  logic [NCPU-1:0] cpu_timer = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [4*NCPU-1:0] cpu_pil;
  int checks = 0, fails = 0;

  irq_route #(.NCPU(NCPU), .PAGE_W(PAGE_W)) dut (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cpu_timer(cpu_timer),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_pil(cpu_pil));

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] ca(input int c, input int o);
    return AW'((c << PAGE_W) + o);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] pil(input int c);
    return 32'(cpu_pil[4*c +: 4]);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(SYS + 4, d);  check("R2 mask reset", d, 32'hFFFF_FFFF);
    rd(SYS + 16, d); check("R6 target reset", d, 32'd0);
    check("R10 no level after reset", 32'(cpu_pil), 32'd0);
  endtask

  task automatic t_raw_pending;
    logic [31:0] d;
    dev_irq = 32'hFFFF_FFFF; idle(2);
    rd(SYS, d); check("R11 raw pending masked sources", d, 32'h405F_FF80);
    check("R3 all masked keeps levels 0", 32'(cpu_pil), 32'd0);
    dev_irq = 32'h0000_0400; idle(2);
    rd(SYS, d); check("R11 raw pending single", d, 32'h0000_0400);
    dev_irq = '0; idle(2);
  endtask

  task automatic t_mask_all;
    logic [31:0] d;
    dev_irq = 32'h0008_0000; idle(1);
    wr(SYS + 8, 32'h7FFF_FFFF);
    rd(SYS + 4, d); check("R2 clear enables", d, 32'h8000_0000);
    check("R3 mask-all blocks", pil(0), 32'd0);
    wr(SYS + 8, 32'h8000_0000);
    check("R7 timer level after unmask", pil(0), 32'd10);
    wr(SYS + 12, 32'h8000_0000);
    check("R3 mask-all set again", pil(0), 32'd0);
    wr(SYS + 8, 32'h8000_0000);
  endtask

  task automatic t_write_bits;
    logic [31:0] d;
    wr(SYS + 12, 32'd0);
    rd(SYS + 4, d); check("R1 zero set no effect", d, 32'd0);
    wr(SYS + 12, 32'h0008_0000);
    rd(SYS + 4, d); check("R2 set disables", d, 32'h0008_0000);
    check("R2 masked source gives 0", pil(0), 32'd0);
    wr(SYS + 8, 32'h0000_0001);
    rd(SYS + 4, d); check("R1 other bit clear keeps", d, 32'h0008_0000);
    wr(SYS + 8, 32'h0008_0000);
    check("R2 re-enabled", pil(0), 32'd10);
    dev_irq = '0; idle(2);
  endtask

  task automatic t_mapping;
    int bits[16] = '{7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17, 18, 19, 20, 22, 30};
    int lvls[16] = '{2, 3, 5, 7, 9, 11, 13, 12, 12, 6, 13, 4, 10, 8, 11, 9};
    for (int i = 0; i < 16; i++) begin
      dev_irq = 32'd1 << bits[i]; idle(2);
      check(bits[i] <= 13 ? "R8 slot level" : "R7 source level", pil(0), 32'(lvls[i]));
    end
    dev_irq = 32'h0002_1000; idle(2);
    check("R10 highest of two", pil(0), 32'd13);
    dev_irq = 32'h0004_0080; idle(2);
    check("R10 highest of scsi/slot0", pil(0), 32'd4);
    dev_irq = '0; idle(2);
    check("R10 none pending", pil(0), 32'd0);
  endtask

  task automatic t_target;
    logic [31:0] d;
    dev_irq = 32'h0040_0000;
    wr(SYS + 16, 32'd2);
    rd(SYS + 16, d); check("R6 target readback", d, 32'd2);
    check("R6 target gets source", pil(2), 32'd11);
    check("R6 old target silent", pil(0), 32'd0);
    wr(SYS + 16, 32'd0);
    check("R6 back to cpu0", pil(0), 32'd11);
    check("R6 cpu2 silent", pil(2), 32'd0);
    dev_irq = '0; idle(2);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    wr(ca(1, 8), 32'h0040_0000);
    check("R5 ipi level", pil(1), 32'd6);
    check("R4 other cpu untouched", pil(0), 32'd0);
    rd(ca(1, 0), d); check("R4 cpu1 pending read", d, 32'h0040_0000);
    wr(ca(1, 4), 32'h0080_0000);
    check("R1 clear other bit keeps", pil(1), 32'd6);
    idle(5);
    check("R5 soft stays pending", pil(1), 32'd6);
    wr(ca(1, 8), 32'h0800_0000);
    check("R10 max soft", pil(1), 32'd11);
    wr(ca(1, 4), 32'h0840_0000);
    check("R5 cleared", pil(1), 32'd0);
    dev_irq = 32'h0008_0000;
    wr(SYS + 16, 32'd3);
    wr(ca(3, 8), 32'h8000_0000);
    check("R10 soft 15 over system 10", pil(3), 32'd15);
    wr(ca(3, 4), 32'h8000_0000);
    check("R10 system after soft clear", pil(3), 32'd10);
    wr(SYS + 16, 32'd0);
    dev_irq = '0; idle(2);
  endtask

  task automatic t_timer;
    logic [31:0] d;
    cpu_timer = 4'b0100; idle(2);
    check("R9 timer level", pil(2), 32'd14);
    check("R9 other cpu", pil(1), 32'd0);
    rd(ca(2, 0), d); check("R9 pending bit7", d, 32'h0000_0080);
    cpu_timer = '0; idle(2);
    check("R9 timer gone", pil(2), 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL R10 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    t_reset();
    t_raw_pending();
    t_mask_all();
    t_write_bits();
    t_mapping();
    t_target();
    t_soft();
    t_timer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule